// File: doc/BRIEF.md
# Dual-Channel DMA Request Controller

This block lets an external DMA engine move words into or out of three on-chip stream FIFOs (pixel, code and attribute) over a request/acknowledge handshake. Two channels work independently. Each one is pointed at one FIFO, given a direction, and set to either single-word or burst requesting. A channel raises its request line when the selected FIFO holds enough words (when the DMA reads) or has enough free slots (when the DMA writes). It emits one pop or push strobe to that FIFO for every acknowledge it sees.

The acknowledge lines come from outside the clock domain. Each one passes through a two-flop synchroniser, and only its rising edge counts, so a single acknowledge moves exactly one word no matter how long it is held. If both channels are enabled on the same FIFO, a configuration error is flagged and the higher-numbered channel is held idle. The FIFOs themselves are outside the block; it sees only their fill and free counts and drives their strobes.

Top module: `dma_req_ctrl`

## Requirements
- R1: After reset, all request lines, pop strobes, push strobes and the error flag are low.
- R2: The channel select field encodes 0 = pixel FIFO, 1 = code FIFO and 2 = attribute FIFO. A channel strobes only the FIFO it selected, and select value 3 keeps the channel idle.
- R3: Direction bit 0 means the DMA reads. The channel then gates on the FIFO fill count and pulses that FIFO's pop strobe. Direction bit 1 means the DMA writes. The channel then gates on the free count and pulses the push strobe.
- R4: In single mode the request rises when the gating count is at least 1. It falls on the clock after an acknowledge edge is taken. It rises again only after the synchronised acknowledge has gone low and the count is still at least 1.
- R5: In burst mode with length field L, the request rises only when the gating count is at least L+1. It then stays high for L+1 acknowledge edges and falls after the last one.
- R6: The acknowledge passes through two synchronising flops. A rising edge gives exactly one strobe, one cycle wide, visible after the second clock edge that follows the acknowledge rising.
- R7: An acknowledge that arrives while the channel's request is low produces no strobe.
- R8: When two enabled channels select the same valid FIFO, the error flag is high and the higher-numbered channel keeps its request low.
- R9: Clearing a channel's enable drops its request at the next clock edge. Later acknowledges then move no word.
- R10: Both channels can request and move words at the same time on different FIFOs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_en_i | input | NUM_CH | Per-channel enable |
| cfg_sel_i | input | NUM_CH*2 | Per-channel FIFO select, 2 bits each |
| cfg_dir_i | input | NUM_CH | Per-channel direction, 1 = write into FIFO |
| cfg_burst_i | input | NUM_CH | Per-channel burst mode enable |
| cfg_blen_i | input | NUM_CH*BLEN_W | Per-channel burst length minus one |
| fifo_fill_i | input | NUM_FIFO*LVL_W | Words held in each FIFO |
| fifo_free_i | input | NUM_FIFO*LVL_W | Free slots in each FIFO |
| dack_i | input | NUM_CH | Asynchronous acknowledge per channel |
| dreq_o | output | NUM_CH | Request per channel |
| fifo_pop_o | output | NUM_FIFO | One-cycle pop strobe per FIFO |
| fifo_push_o | output | NUM_FIFO | One-cycle push strobe per FIFO |
| cfg_err_o | output | 1 | Two channels mapped onto one FIFO |

## Verification
Assertions check several rules on every cycle. A strobe only happens while the request is high and never lasts two cycles. A single-mode request falls right after its strobe. A disabled channel's request falls on the next edge. No FIFO is pushed and popped together, and the idled channel stays silent during a mapping conflict. The bench scenarios are needed for the rest: that burst length and gating thresholds match the programmed values, that each held acknowledge moves exactly one word, that a stray acknowledge moves nothing, and that two channels run side by side. These come from a cycle-accurate reference model compared with the outputs on every clock.

// File: rtl/dma_req_pkg.sv
package dma_req_pkg;
  localparam int unsigned SEL_W = 2;
  typedef enum logic [1:0] {CH_IDLE, CH_REQ, CH_DRAIN} ch_state_e;
endpackage

// File: rtl/dma_ack_sync.sv
module dma_ack_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ack_i,
  output logic ack_lvl_o,
  output logic ack_rise_o
);
  logic [STAGES:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q[0] <= 1'b0;
    else         pipe_q[0] <= ack_i;
  end

  for (genvar s = 1; s <= STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q[s] <= 1'b0;
      else         pipe_q[s] <= pipe_q[s-1];
    end
  end

  assign ack_lvl_o  = pipe_q[STAGES-1];
  assign ack_rise_o = pipe_q[STAGES-1] & ~pipe_q[STAGES];
endmodule

// File: rtl/dma_cfg_check.sv
module dma_cfg_check #(
  parameter int unsigned NUM_CH   = 2,
  parameter int unsigned NUM_FIFO = 3,
  parameter int unsigned SEL_W    = 2
) (
  input  logic [NUM_CH-1:0]       en_i,
  input  logic [NUM_CH*SEL_W-1:0] sel_i,
  output logic [NUM_CH-1:0]       act_o,
  output logic                    err_o
);
  always_comb begin
    act_o = '0;
    err_o = 1'b0;
    for (int c = 0; c < NUM_CH; c++) begin
      logic clash;
      clash = 1'b0;
      for (int p = 0; p < c; p++) begin
        if (en_i[p] && sel_i[p*SEL_W +: SEL_W] == sel_i[c*SEL_W +: SEL_W]) clash = 1'b1;
      end
      if (en_i[c] && (int'(sel_i[c*SEL_W +: SEL_W]) < NUM_FIFO)) begin
        act_o[c] = ~clash;
        if (clash) err_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dma_chan.sv
module dma_chan
  import dma_req_pkg::*;
#(
  parameter int unsigned LVL_W  = 6,
  parameter int unsigned BLEN_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              act_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic              dir_i,
  input  logic              burst_i,
  input  logic [BLEN_W-1:0] blen_i,
  input  logic [LVL_W-1:0]  avail_i,
  input  logic              ack_lvl_i,
  input  logic              ack_rise_i,
  output logic              dreq_o,
  output logic              stb_o,
  output logic [SEL_W-1:0]  stb_sel_o,
  output logic              stb_dir_o
);
  localparam int unsigned CNT_W = BLEN_W + 1;
  localparam int unsigned CMP_W = (LVL_W > CNT_W) ? LVL_W : CNT_W;

  ch_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             burst_q;
  logic [CNT_W-1:0] need;
  logic             ready;

  assign need  = burst_i ? (CNT_W'(blen_i) + CNT_W'(1)) : CNT_W'(1);
  assign ready = CMP_W'(avail_i) >= CMP_W'(need);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= CH_IDLE;
      cnt_q     <= '0;
      burst_q   <= 1'b0;
      stb_sel_o <= '0;
      stb_dir_o <= 1'b0;
    end else begin
      unique case (state_q)
        CH_IDLE: if (act_i && ready) begin
          state_q   <= CH_REQ;
          cnt_q     <= need;
          burst_q   <= burst_i;
          stb_sel_o <= sel_i;
          stb_dir_o <= dir_i;
        end
        CH_REQ: begin
          if (!act_i) state_q <= CH_IDLE;
          else if (ack_rise_i) begin
            if (burst_q && cnt_q > CNT_W'(1)) cnt_q <= cnt_q - CNT_W'(1);
            else                              state_q <= CH_DRAIN;
          end
        end
        CH_DRAIN: if (!act_i || !ack_lvl_i) state_q <= CH_IDLE;
        default: state_q <= CH_IDLE;
      endcase
    end
  end

  assign dreq_o = (state_q == CH_REQ);
  assign stb_o  = (state_q == CH_REQ) && ack_rise_i;

  // R6
  stb_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) stb_o |-> dreq_o);
  // R6
  stb_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) stb_o |=> !stb_o);
  // R4
  single_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_o && !burst_q && act_i) |=> !dreq_o);
  // R9
  off_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) !act_i |=> !dreq_o);
endmodule

// File: rtl/dma_req_ctrl.sv
module dma_req_ctrl
  import dma_req_pkg::*;
#(
  parameter int unsigned NUM_CH   = 2,
  parameter int unsigned NUM_FIFO = 3,
  parameter int unsigned LVL_W    = 6,
  parameter int unsigned BLEN_W   = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_CH-1:0]          cfg_en_i,
  input  logic [NUM_CH*SEL_W-1:0]    cfg_sel_i,
  input  logic [NUM_CH-1:0]          cfg_dir_i,
  input  logic [NUM_CH-1:0]          cfg_burst_i,
  input  logic [NUM_CH*BLEN_W-1:0]   cfg_blen_i,
  input  logic [NUM_FIFO*LVL_W-1:0]  fifo_fill_i,
  input  logic [NUM_FIFO*LVL_W-1:0]  fifo_free_i,
  input  logic [NUM_CH-1:0]          dack_i,
  output logic [NUM_CH-1:0]          dreq_o,
  output logic [NUM_FIFO-1:0]        fifo_pop_o,
  output logic [NUM_FIFO-1:0]        fifo_push_o,
  output logic                       cfg_err_o
);
  logic [NUM_CH-1:0]       act;
  logic [NUM_CH-1:0]       stb;
  logic [NUM_CH-1:0]       stb_dir;
  logic [NUM_CH*SEL_W-1:0] stb_sel;

  dma_cfg_check #(.NUM_CH(NUM_CH), .NUM_FIFO(NUM_FIFO), .SEL_W(SEL_W)) u_cfg (
    .en_i (cfg_en_i),
    .sel_i(cfg_sel_i),
    .act_o(act),
    .err_o(cfg_err_o)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic             ack_lvl, ack_rise;
    logic [LVL_W-1:0] avail;
    logic [SEL_W-1:0] sel_c;

    assign sel_c = cfg_sel_i[c*SEL_W +: SEL_W];

    always_comb begin
      avail = '0;
      for (int f = 0; f < NUM_FIFO; f++) begin
        if (int'(sel_c) == f)
          avail = cfg_dir_i[c] ? fifo_free_i[f*LVL_W +: LVL_W] : fifo_fill_i[f*LVL_W +: LVL_W];
      end
    end

    dma_ack_sync #(.STAGES(2)) u_sync (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .ack_i     (dack_i[c]),
      .ack_lvl_o (ack_lvl),
      .ack_rise_o(ack_rise)
    );

    dma_chan #(.LVL_W(LVL_W), .BLEN_W(BLEN_W)) u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .act_i     (act[c]),
      .sel_i     (sel_c),
      .dir_i     (cfg_dir_i[c]),
      .burst_i   (cfg_burst_i[c]),
      .blen_i    (cfg_blen_i[c*BLEN_W +: BLEN_W]),
      .avail_i   (avail),
      .ack_lvl_i (ack_lvl),
      .ack_rise_i(ack_rise),
      .dreq_o    (dreq_o[c]),
      .stb_o     (stb[c]),
      .stb_sel_o (stb_sel[c*SEL_W +: SEL_W]),
      .stb_dir_o (stb_dir[c])
    );
  end

  always_comb begin
    fifo_pop_o  = '0;
    fifo_push_o = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      for (int f = 0; f < NUM_FIFO; f++) begin
        if (stb[c] && int'(stb_sel[c*SEL_W +: SEL_W]) == f) begin
          if (stb_dir[c]) fifo_push_o[f] = 1'b1;
          else            fifo_pop_o[f]  = 1'b1;
        end
      end
    end
  end

  // R2
  no_dual_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_pop_o & fifo_push_o) == '0);

  if (NUM_CH > 1) begin : g_conf_chk
    // R8
    conflict_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_err_o && $past(cfg_err_o) && $past(rst_ni)) |-> !dreq_o[NUM_CH-1]);
  end
endmodule

// File: tb/dma_req_ctrl_tb.sv
module dma_req_ctrl_tb;
  localparam int LVL_W = 6;
  localparam int BLEN_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic en [2], dir [2], bst [2], dack [2];
  logic [1:0] sel [2];
  logic [BLEN_W-1:0] blen [2];
  int fill_m [3], free_m [3];
  logic [3*LVL_W-1:0] fill_p, free_p;
  logic [1:0] dreq;
  logic [2:0] pop, push;
  logic err;

  dma_req_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_en_i({en[1], en[0]}), .cfg_sel_i({sel[1], sel[0]}),
    .cfg_dir_i({dir[1], dir[0]}), .cfg_burst_i({bst[1], bst[0]}),
    .cfg_blen_i({blen[1], blen[0]}),
    .fifo_fill_i(fill_p), .fifo_free_i(free_p),
    .dack_i({dack[1], dack[0]}),
    .dreq_o(dreq), .fifo_pop_o(pop), .fifo_push_o(push), .cfg_err_o(err)
  );

  int checks = 0, errors = 0, cycles = 0;
  int pop_seen [3], push_seen [3];
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference model state
  int st [2], cnt [2], lsel [2];
  bit ldir [2], lbst [2], f1 [2], f2 [2], f3 [2];

  function automatic bit m_act(int c);
    bit conf;
    conf = en[0] && en[1] && sel[0] == sel[1] && sel[0] < 3;
    if (c == 0) return en[0] && sel[0] < 3;
    return en[1] && sel[1] < 3 && !conf;
  endfunction

  function automatic int m_avail(int c);
    int s = int'(sel[c]);
    if (s > 2) return 0;
    return dir[c] ? int'(free_p[s*LVL_W +: LVL_W]) : int'(fill_p[s*LVL_W +: LVL_W]);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) begin
        st[c] = 0; cnt[c] = 0; lsel[c] = 0; ldir[c] = 0; lbst[c] = 0;
        f1[c] = 0; f2[c] = 0; f3[c] = 0;
      end
    end else begin
      for (int c = 0; c < 2; c++) begin
        bit rise, a;
        int need;
        rise = f2[c] && !f3[c];
        a = m_act(c);
        need = bst[c] ? int'(blen[c]) + 1 : 1;
        case (st[c])
          0: if (a && m_avail(c) >= need) begin
            st[c] = 1; cnt[c] = need; lsel[c] = int'(sel[c]); ldir[c] = dir[c]; lbst[c] = bst[c];
          end
          1: if (!a) st[c] = 0;
             else if (rise) begin
               if (lbst[c] && cnt[c] > 1) cnt[c]--; else st[c] = 2;
             end
          default: if (!a || !f2[c]) st[c] = 0;
        endcase
        f3[c] = f2[c]; f2[c] = f1[c]; f1[c] = dack[c];
        if (st[c] == 1 && f2[c] && !f3[c]) begin
          if (ldir[c]) free_m[lsel[c]]--; else fill_m[lsel[c]]--;
        end
      end
    end
  end

  always @(negedge clk) begin
    for (int f = 0; f < 3; f++) begin
      fill_p[f*LVL_W +: LVL_W] <= LVL_W'(fill_m[f]);
      free_p[f*LVL_W +: LVL_W] <= LVL_W'(free_m[f]);
    end
  end

  // per-cycle comparison, 1 ns after the edge
  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      logic [2:0] ep, eu;
      ep = '0; eu = '0;
      for (int c = 0; c < 2; c++) begin
        chk(dreq[c] == (st[c] == 1), "R4/R5 request", int'(dreq[c]), int'(st[c] == 1));
        if (st[c] == 1 && f2[c] && !f3[c]) begin
          if (ldir[c]) eu[lsel[c]] = 1'b1; else ep[lsel[c]] = 1'b1;
        end
      end
      chk(pop == ep, "R6 pop strobe", int'(pop), int'(ep));
      chk(push == eu, "R6 push strobe", int'(push), int'(eu));
      chk(err == (en[0] && en[1] && sel[0] == sel[1] && sel[0] < 3), "R8 error flag",
          int'(err), int'(en[0] && en[1] && sel[0] == sel[1] && sel[0] < 3));
      for (int f = 0; f < 3; f++) begin
        if (pop[f]) pop_seen[f]++;
        if (push[f]) push_seen[f]++;
      end
    end
  end

  task automatic finish_run();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      finish_run();
    end
  end

  task automatic wait_req(input int c, input string req);
    int n = 0;
    while (!dreq[c] && n < 50) begin @(negedge clk); n++; end
    chk(dreq[c] == 1'b1, req, int'(dreq[c]), 1);
  endtask

  task automatic do_ack(input int c);
    @(negedge clk); dack[c] = 1'b1;
    repeat (4) @(negedge clk);
    dack[c] = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    for (int c = 0; c < 2; c++) begin
      en[c] = 0; dir[c] = 0; bst[c] = 0; dack[c] = 0; sel[c] = 0; blen[c] = 0;
    end
    for (int f = 0; f < 3; f++) begin fill_m[f] = 0; free_m[f] = 0; pop_seen[f] = 0; push_seen[f] = 0; end
    fill_p = '0; free_p = '0;
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R1 reset state
    chk(dreq == 2'b00 && pop == 3'b000 && push == 3'b000 && !err, "R1 reset", int'({dreq, pop, push}), 0);

    // R4 R3 single mode, DMA reads pixel FIFO
    fill_m[0] = 3; en[0] = 1; sel[0] = 0; dir[0] = 0;
    for (int i = 0; i < 3; i++) begin wait_req(0, "R4 single request"); do_ack(0); end
    idle(6);
    chk(dreq[0] == 1'b0, "R4 no request when empty", int'(dreq[0]), 0);
    chk(pop_seen[0] == 3, "R3 pops on pixel FIFO", pop_seen[0], 3);
    chk(push_seen[0] == 0 && pop_seen[1] == 0 && pop_seen[2] == 0, "R2 other FIFOs untouched",
        push_seen[0] + pop_seen[1] + pop_seen[2], 0);

    // R2 select 3 is idle
    fill_m[0] = 5; sel[0] = 3; idle(10);
    chk(dreq[0] == 1'b0, "R2 select 3 idle", int'(dreq[0]), 0);
    en[0] = 0; fill_m[0] = 0; sel[0] = 0;

    // R5 burst, DMA writes code FIFO, length 4
    free_m[1] = 5; en[1] = 1; sel[1] = 1; dir[1] = 1; bst[1] = 1; blen[1] = 3;
    wait_req(1, "R5 burst request");
    for (int i = 0; i < 4; i++) do_ack(1);
    idle(6);
    chk(push_seen[1] == 4, "R5 burst length", push_seen[1], 4);
    chk(dreq[1] == 1'b0, "R5 below threshold", int'(dreq[1]), 0);
    free_m[1] = 3; idle(8);
    chk(dreq[1] == 1'b0, "R5 three free under four", int'(dreq[1]), 0);

    // R7 ack while request low
    do_ack(1);
    idle(4);
    chk(push_seen[1] == 4, "R7 stray ack ignored", push_seen[1], 4);
    free_m[1] = 4;
    wait_req(1, "R5 burst at threshold");
    for (int i = 0; i < 4; i++) do_ack(1);
    idle(4);
    chk(push_seen[1] == 8, "R5 second burst", push_seen[1], 8);
    en[1] = 0; bst[1] = 0;

    // R8 conflict on attribute FIFO
    fill_m[2] = 2; free_m[2] = 2;
    en[0] = 1; sel[0] = 2; dir[0] = 0; en[1] = 1; sel[1] = 2; dir[1] = 1;
    idle(3);
    chk(err == 1'b1, "R8 error flag set", int'(err), 1);
    chk(dreq[1] == 1'b0, "R8 second channel idle", int'(dreq[1]), 0);
    do_ack(0); wait_req(0, "R8 first channel runs"); do_ack(0);
    idle(6);
    chk(pop_seen[2] == 2 && push_seen[2] == 0, "R8 only first channel moves", pop_seen[2] * 10 + push_seen[2], 20);
    en[0] = 0; en[1] = 0;

    // R9 disable mid-burst
    fill_m[0] = 10; en[0] = 1; sel[0] = 0; dir[0] = 0; bst[0] = 1; blen[0] = 7;
    wait_req(0, "R9 burst started");
    do_ack(0);
    en[0] = 0; idle(2);
    chk(dreq[0] == 1'b0, "R9 request drops", int'(dreq[0]), 0);
    do_ack(0); idle(4);
    chk(pop_seen[0] == 4, "R9 ack after disable moves nothing", pop_seen[0], 4);
    bst[0] = 0; fill_m[0] = 0;

    // R10 concurrent channels
    fill_m[0] = 2; free_m[1] = 2;
    en[0] = 1; sel[0] = 0; dir[0] = 0;
    en[1] = 1; sel[1] = 1; dir[1] = 1;
    fork
      for (int i = 0; i < 2; i++) begin wait_req(0, "R10 ch0 request"); do_ack(0); end
      for (int i = 0; i < 2; i++) begin wait_req(1, "R10 ch1 request"); do_ack(1); end
    join
    idle(6);
    chk(pop_seen[0] == 6, "R10 ch0 words", pop_seen[0], 6);
    chk(push_seen[1] == 10, "R10 ch1 words", push_seen[1], 10);
    finish_run();
  end
endmodule